// File: doc/BRIEF.md
# Measurement Strobe and Timestamp Recorder

This block produces the periodic measurement strobe that paces a loss-sampling system and keeps a time record for every measurement cycle. The strobe comes from one of three sources chosen at run time: every pulse of an external marker, every Nth marker pulse, or a divided internal clock. A divided internal clock has a floor on its period, so the strobe cannot run faster than the integrators allow.

A free-running timebase keeps a 32-bit seconds count and a 24-bit microsecond count. The microsecond count returns to zero at each second boundary. On every strobe the block drives one write to an external timestamp RAM. The write address is a 16-bit circular pointer that moves in step with the sample buffers held elsewhere. A reset command puts this pointer at all ones, so the first write after the command lands at address zero. A freeze command stops the writes so that the history before an abort is kept.

Three latch channels count strobes, each against its own interval. When a channel reaches its interval it emits a one-cycle latch pulse, captures the current timestamp and sets a sticky interrupt flag. Software clears the flag by writing a one to it.

Top module: `mstk_top`

## Requirements
- R1: The microsecond count advances by one every CLK_PER_US clocks. When it is at US_PER_SEC-1 and advances, it goes to 0 and the seconds count increments.
- R2: A `set_time` pulse loads `set_sec` into the seconds count and clears the microsecond count, both visible one clock later.
- R3: In mode 0 (`strobe_mode`=2'b00), `meas_strobe` is high for one clock, the clock after each `marker` pulse.
- R4: In mode 1 (2'b01), `meas_strobe` fires once per `marker_div` marker pulses. A `marker_div` of 0 acts as 1.
- R5: In mode 2 or 3 (`strobe_mode[1]`=1), `meas_strobe` repeats every max(`clk_div`, MIN_PERIOD_US*CLK_PER_US) clocks.
- R6: After `rst_n` low or a `cmd_reset` pulse, `buf_ptr` is 16'hFFFF, `frozen` is 0, and the marker, clock and latch counters start from zero.
- R7: Every strobe while not frozen gives one `buf_wr_en` pulse in the clock after the strobe. `buf_ptr` (the write address) then equals its old value plus one, and `buf_wr_data` holds {seconds, microseconds} as sampled in the strobe clock.
- R8: A `cmd_freeze` pulse sets `frozen`. From that clock onward, strobes cause no write and `buf_ptr` holds, until `cmd_reset`.
- R9: Latch k (bits [16k+15:16k] of `lat_period`) pulses `lat_pulse[k]` on every `lat_period`-th strobe, counted from the last reset. A period of 0 disables the latch. Latches keep running while frozen.
- R10: With each latch pulse, `lat_stamp` bits [56k+55:56k] hold the timestamp of that strobe, which is the same value written to the buffer for that strobe. `irq[k]` is set.
- R11: `irq[k]` stays set until a clock with `irq_clear[k]`=1. A latch event in that same clock keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| marker | input | 1 | External marker, one-clock pulses |
| strobe_mode | input | 2 | 00 marker, 01 divided marker, 1x internal divider |
| marker_div | input | 8 | Marker divide ratio |
| clk_div | input | 16 | Internal strobe period in clocks |
| set_time | input | 1 | Load seconds, clear microseconds |
| set_sec | input | 32 | Seconds value to load |
| cmd_reset | input | 1 | Buffer-reset command pulse |
| cmd_freeze | input | 1 | Freeze command pulse |
| lat_period | input | 48 | Three 16-bit latch intervals in strobes |
| irq_clear | input | 3 | Write-one-to-clear for interrupt flags |
| meas_strobe | output | 1 | Measurement strobe |
| buf_wr_en | output | 1 | Timestamp RAM write enable |
| buf_ptr | output | 16 | Circular pointer and write address |
| buf_wr_data | output | 56 | Timestamp {sec, us} to write |
| frozen | output | 1 | Buffer frozen |
| now_sec | output | 32 | Current seconds |
| now_us | output | 24 | Current microseconds |
| lat_pulse | output | 3 | Latch pulses |
| lat_stamp | output | 168 | Captured timestamps, latch 0 in low bits |
| irq | output | 3 | Sticky latch interrupt flags |

## Verification
The bench checks the microsecond rollover on both sides of the boundary. A design that wrapped one count late would show US_PER_SEC on `now_us`, and one that forgot to carry would leave the seconds count unchanged. It places a freeze between strobes and expects the pointer and write count to stop while the strobe count keeps rising, which exposes a freeze that only gates the pointer or also stops the strobe. It sets the internal divider below the floor and expects the clamped gap, and it gives a zero marker ratio and expects every marker to pass. It times a write-one-to-clear to land on the same clock as a latch event, so a design where the clear wins loses an interrupt.

// File: rtl/mstk_pkg.sv
package mstk_pkg;

  typedef struct packed {
    logic [31:0] sec;
    logic [23:0] us;
  } stamp_t;

  localparam int STAMP_W = $bits(stamp_t);

  // next microsecond value, wrapping after the last count of a second
  function automatic logic [23:0] us_next(input logic [23:0] u, input logic [23:0] last);
    return (u == last) ? 24'd0 : u + 24'd1;
  endfunction

  // internal strobe period with the minimum enforced
  function automatic logic [15:0] clamp_period(input logic [15:0] req, input logic [15:0] floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // marker divide ratio, zero read as one
  function automatic logic [7:0] ratio_of(input logic [7:0] d);
    return (d == 8'd0) ? 8'd1 : d;
  endfunction

endpackage

// File: rtl/mstk_timebase.sv
module mstk_timebase import mstk_pkg::*; #(
  parameter int CLK_PER_US = 100,
  parameter int US_PER_SEC = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_time,
  input  logic [31:0] set_sec,
  output stamp_t      now,
  output logic        us_tick
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);
  localparam logic [23:0] US_LAST = 24'(US_PER_SEC - 1);

  logic [PRE_W-1:0] pre;
  logic             sec_wrap;

  assign us_tick  = (pre == PRE_LAST);
  assign sec_wrap = us_tick && (now.us == US_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      now <= '0;
    end else if (set_time) begin
      pre     <= '0;
      now.sec <= set_sec;
      now.us  <= '0;
    end else begin
      pre <= us_tick ? '0 : pre + 1'b1;
      if (us_tick) begin
        now.us <= us_next(now.us, US_LAST);
        if (sec_wrap) now.sec <= now.sec + 32'd1;
      end
    end
  end

  // R1: microseconds never reach a full second
  p_us_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    now.us <= US_LAST);
  // R1: rollover clears microseconds and carries into seconds
  p_sec_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wrap && !set_time) |=> (now.us == 24'd0 && now.sec == $past(now.sec) + 32'd1));
  // R2: a load shows on the next clock
  p_set_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_time |=> (now.sec == $past(set_sec) && now.us == 24'd0));
endmodule

// File: rtl/mstk_strobe_gen.sv
module mstk_strobe_gen import mstk_pkg::*; #(
  parameter int MIN_CLKS = 1500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        marker,
  input  logic [1:0]  mode,
  input  logic [7:0]  marker_div,
  input  logic [15:0] clk_div,
  output logic        strobe
);
  localparam logic [15:0] FLOOR = 16'(MIN_CLKS);

  logic [7:0]  mcnt;
  logic [15:0] ccnt;
  logic [15:0] period;
  logic        marker_hit, clock_hit, fire;

  assign period     = clamp_period(clk_div, FLOOR);
  assign marker_hit = marker && (mcnt >= ratio_of(marker_div) - 8'd1);
  assign clock_hit  = (ccnt >= period - 16'd1);

  always_comb begin
    if (mode[1])      fire = clock_hit;
    else if (mode[0]) fire = marker_hit;
    else              fire = marker;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      mcnt   <= '0;
      ccnt   <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= fire;
      if (mode == 2'b01 && marker) mcnt <= marker_hit ? 8'd0 : mcnt + 8'd1;
      if (mode[1]) ccnt <= clock_hit ? 16'd0 : ccnt + 16'd1;
      else         ccnt <= '0;
    end
  end

  // R3: direct mode passes each marker one clock later
  p_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && marker && !restart) |=> strobe);
  // R5: clock mode never produces back-to-back strobes
  p_strobe_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && $past(mode[1]) && strobe) |=> !strobe);
endmodule

// File: rtl/mstk_latch.sv
module mstk_latch import mstk_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        strobe,
  input  logic [15:0] period,
  input  stamp_t      now,
  input  logic        clear,
  output logic        pulse,
  output stamp_t      stamp,
  output logic        irq
);
  logic [15:0] cnt;
  logic        hit;

  assign hit = strobe && (period != 16'd0) && (cnt >= period - 16'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
      stamp <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= hit | (irq & ~clear);
      if (restart) begin
        cnt   <= '0;
        pulse <= 1'b0;
      end else begin
        pulse <= hit;
        if (hit) stamp <= now;
        if (strobe) cnt <= (period == 16'd0 || hit) ? 16'd0 : cnt + 16'd1;
      end
    end
  end

  // R9: a disabled latch stays quiet
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (period == 16'd0) |=> !pulse);
  // R10: the captured stamp is the one seen in the strobe clock
  p_stamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (stamp == $past(now)));
  // R11: flag holds until cleared
  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clear) |=> irq);
endmodule

// File: rtl/mstk_top.sv
module mstk_top import mstk_pkg::*; #(
  parameter int CLK_PER_US    = 100,
  parameter int US_PER_SEC    = 1000000,
  parameter int MIN_PERIOD_US = 15,
  parameter int NUM_LATCH     = 3,
  parameter int PTR_W         = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         marker,
  input  logic [1:0]                   strobe_mode,
  input  logic [7:0]                   marker_div,
  input  logic [15:0]                  clk_div,
  input  logic                         set_time,
  input  logic [31:0]                  set_sec,
  input  logic                         cmd_reset,
  input  logic                         cmd_freeze,
  input  logic [16*NUM_LATCH-1:0]      lat_period,
  input  logic [NUM_LATCH-1:0]         irq_clear,
  output logic                         meas_strobe,
  output logic                         buf_wr_en,
  output logic [PTR_W-1:0]             buf_ptr,
  output logic [STAMP_W-1:0]           buf_wr_data,
  output logic                         frozen,
  output logic [31:0]                  now_sec,
  output logic [23:0]                  now_us,
  output logic [NUM_LATCH-1:0]         lat_pulse,
  output logic [STAMP_W*NUM_LATCH-1:0] lat_stamp,
  output logic [NUM_LATCH-1:0]         irq
);
  localparam int MIN_CLKS = MIN_PERIOD_US * CLK_PER_US;

  stamp_t now;
  logic   us_tick;
  logic   write_go;

  mstk_timebase #(.CLK_PER_US(CLK_PER_US), .US_PER_SEC(US_PER_SEC)) u_tb (
    .clk(clk), .rst_n(rst_n), .set_time(set_time), .set_sec(set_sec),
    .now(now), .us_tick(us_tick)
  );

  mstk_strobe_gen #(.MIN_CLKS(MIN_CLKS)) u_sg (
    .clk(clk), .rst_n(rst_n), .restart(cmd_reset), .marker(marker),
    .mode(strobe_mode), .marker_div(marker_div), .clk_div(clk_div),
    .strobe(meas_strobe)
  );

  for (genvar k = 0; k < NUM_LATCH; k++) begin : g_latch
    stamp_t st;
    mstk_latch u_lt (
      .clk(clk), .rst_n(rst_n), .restart(cmd_reset), .strobe(meas_strobe),
      .period(lat_period[16*k +: 16]), .now(now), .clear(irq_clear[k]),
      .pulse(lat_pulse[k]), .stamp(st), .irq(irq[k])
    );
    assign lat_stamp[STAMP_W*k +: STAMP_W] = st;
  end

  assign now_sec  = now.sec;
  assign now_us   = now.us;
  assign write_go = meas_strobe && !frozen && !cmd_freeze && !cmd_reset;

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_reset) begin
      buf_ptr     <= '1;
      frozen      <= 1'b0;
      buf_wr_en   <= 1'b0;
      buf_wr_data <= '0;
    end else begin
      if (cmd_freeze) frozen <= 1'b1;
      buf_wr_en <= write_go;
      if (write_go) begin
        buf_ptr     <= buf_ptr + 1'b1;
        buf_wr_data <= now;
      end
    end
  end

  // R6: reset command parks the pointer at all ones
  p_ptr_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (buf_ptr == '1 && !frozen));
  // R7: each accepted strobe advances the pointer by one
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    write_go |=> (buf_wr_en && buf_ptr == $past(buf_ptr) + 1'b1));
  // R8: frozen buffer does not move
  p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !cmd_reset) |=> ($stable(buf_ptr) && !buf_wr_en));
endmodule

// File: tb/sim_mstk_top.sv
module sim_mstk_top;
  localparam int CPU = 2, UPS = 40, MINU = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic marker = 0, set_time = 0, cmd_reset = 0, cmd_freeze = 0;
  logic [1:0] strobe_mode = 0;
  logic [7:0] marker_div = 1;
  logic [15:0] clk_div = 100;
  logic [31:0] set_sec = 0;
  logic [47:0] lat_period = 0;
  logic [2:0] irq_clear = 0;
  logic meas_strobe, buf_wr_en, frozen;
  logic [15:0] buf_ptr;
  logic [55:0] buf_wr_data;
  logic [31:0] now_sec;
  logic [23:0] now_us;
  logic [2:0] lat_pulse, irq;
  logic [167:0] lat_stamp;

  mstk_top #(.CLK_PER_US(CPU), .US_PER_SEC(UPS), .MIN_PERIOD_US(MINU)) u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int n_strobe = 0, n_wr = 0, stamp_bad = 0, stamp_seen = 0;
  int n_lat [3] = '{0, 0, 0};
  logic [15:0] first_addr = 0;

  always begin
    @(posedge clk); #2;
    if (meas_strobe) n_strobe++;
    if (buf_wr_en) begin
      if (n_wr == 0) first_addr = buf_ptr;
      n_wr++;
    end
    for (int k = 0; k < 3; k++) if (lat_pulse[k]) begin
      n_lat[k]++;
      if (buf_wr_en) begin
        stamp_seen++;
        if (lat_stamp[56*k +: 56] != buf_wr_data) stamp_bad++;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon();
    n_strobe = 0; n_wr = 0; stamp_bad = 0; stamp_seen = 0;
    for (int k = 0; k < 3; k++) n_lat[k] = 0;
  endtask

  task automatic do_reset_cmd();
    @(negedge clk); cmd_reset = 1;
    @(negedge clk); cmd_reset = 0;
    clear_mon();
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); marker = 1;
      @(negedge clk); marker = 0;
      clocks(2);
    end
    clocks(3);
  endtask

  task automatic t_reset_state();
    clocks(1);
    check("R6 ptr after reset", buf_ptr, 16'hFFFF);
    check("R6 frozen after reset", frozen, 0);
    check("R11 irq after reset", irq, 0);
    check("R1 us after reset", now_us, 0);
  endtask

  task automatic t_timebase();
    logic [23:0] u1;
    logic [31:0] s1;
    @(negedge clk); set_time = 1; set_sec = 32'd1234;
    @(negedge clk); set_time = 0;
    check("R2 sec loaded", now_sec, 1234);
    check("R2 us cleared", now_us, 0);
    u1 = now_us;
    clocks(20);
    check("R1 us pace", (now_us + UPS - u1) % UPS, 10);
    while (now_us == UPS - 1) @(negedge clk);
    while (now_us != UPS - 1) @(negedge clk);
    s1 = now_sec;
    @(negedge clk);
    check("R1 us hold at last", now_us, UPS - 1);
    @(negedge clk);
    check("R1 us wrap", now_us, 0);
    check("R1 sec carry", now_sec, s1 + 1);
  endtask

  task automatic t_direct();
    strobe_mode = 2'b00; lat_period = 0;
    do_reset_cmd();
    pulses(5);
    check("R3 strobe per marker", n_strobe, 5);
    check("R7 writes", n_wr, 5);
    check("R7 first addr", first_addr, 0);
    check("R7 ptr after 5", buf_ptr, 4);
  endtask

  task automatic t_divided();
    strobe_mode = 2'b01; marker_div = 3;
    do_reset_cmd();
    pulses(9);
    check("R4 div3 strobes", n_strobe, 3);
    check("R7 ptr after div3", buf_ptr, 2);
    marker_div = 0;
    do_reset_cmd();
    pulses(4);
    check("R4 div0 acts as 1", n_strobe, 4);
  endtask

  task automatic gap(input logic [15:0] dv, input int exp);
    int g;
    strobe_mode = 2'b10; clk_div = dv;
    do_reset_cmd();
    while (!meas_strobe) @(negedge clk);
    @(negedge clk);
    g = 1;
    while (!meas_strobe && g < 1000) begin @(negedge clk); g++; end
    check("R5 strobe period", g, exp);
  endtask

  task automatic t_internal();
    gap(16'd40, 40);
    gap(16'd10, CPU * MINU);
    strobe_mode = 2'b00;
  endtask

  task automatic t_freeze();
    strobe_mode = 2'b00;
    do_reset_cmd();
    pulses(2);
    @(negedge clk); cmd_freeze = 1;
    @(negedge clk); cmd_freeze = 0;
    pulses(3);
    check("R8 frozen flag", frozen, 1);
    check("R8 ptr holds", buf_ptr, 1);
    check("R8 no writes when frozen", n_wr, 2);
    check("R8 strobe keeps running", n_strobe, 5);
    do_reset_cmd();
    check("R6 unfreeze on reset", frozen, 0);
    check("R6 ptr parked", buf_ptr, 16'hFFFF);
  endtask

  task automatic t_latch();
    strobe_mode = 2'b00;
    lat_period = {16'd0, 16'd3, 16'd2};
    do_reset_cmd();
    @(negedge clk); irq_clear = 3'b111;
    @(negedge clk); irq_clear = 0;
    pulses(6);
    check("R9 latch0 every 2", n_lat[0], 3);
    check("R9 latch1 every 3", n_lat[1], 2);
    check("R9 latch2 disabled", n_lat[2], 0);
    check("R10 irq set", irq, 3'b011);
    check("R10 stamp matches buffer", stamp_bad, 0);
    check("R10 stamps seen", stamp_seen, 5);
    clocks(5);
    check("R11 irq sticky", irq, 3'b011);
    @(negedge clk); irq_clear = 3'b001;
    @(negedge clk); irq_clear = 0;
    check("R11 w1c clears only bit0", irq, 3'b010);
    lat_period = {16'd0, 16'd0, 16'd1};
    do_reset_cmd();
    @(negedge clk); marker = 1;
    @(negedge clk); marker = 0; irq_clear = 3'b001;
    @(negedge clk); irq_clear = 0;
    check("R11 set wins over clear", irq[0], 1);
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clocks(3);
    rst_n = 1;
    t_reset_state();
    t_timebase();
    t_direct();
    t_divided();
    t_internal();
    t_freeze();
    t_latch();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule